// File: doc/BRIEF.md
# Waveform Sample Capture with Rate Selection

This block picks one of six sample streams and holds the chosen sample in a 24-bit waveform register. There are three phases and two quantities per phase: a 24-bit current sample and a 16-bit filtered voltage sample. All streams share one valid strobe at the base sample rate. A source field chooses current or voltage. A phase field chooses the phase. A rate field lowers the output rate by keeping only every first, second, fourth or eighth strobe.

Each captured sample sets a sample-ready flag. When the mask bit allows it, the flag pulls an active-low interrupt line. The flag stays set until the status-clear pulse arrives, which the host issues when it reads status. Capture never holds back the incoming streams, so the processing that consumes them runs without interruption.

Top module: `wave_capture_top`

## Requirements
- R1: With source code 3'b000, a kept strobe loads the selected phase's 24-bit two's complement current sample into `wave_o` unchanged.
- R2: With source code 3'b001, a kept strobe loads the selected phase's 16-bit voltage sample into the low 16 bits of `wave_o`, and copies its bit 15 into bits 23:16.
- R3: Phase code 2'b00 selects phase A, 2'b01 selects phase B and 2'b10 selects phase C. Phase code 2'b11 captures nothing, and the register keeps its value.
- R4: Source codes 3'b010 through 3'b111 disable capture. `wave_o` holds its last value and the flag is not set.
- R5: Rate code k (0..3) keeps the first strobe after a mode change and then every 2^k-th strobe. Cycles without a strobe do not advance the count.
- R6: A change in the source, phase or rate field restarts the decimation count. The first strobe seen with the new setting is kept.
- R7: Every kept strobe sets `sample_flag_o`. The flag stays set through idle cycles until `status_clr_i`. When a clear and a kept strobe arrive in the same cycle, the flag ends up set.
- R8: `irq_no` is low exactly when `sample_flag_o` is 1 and `ready_mask_i` is 1. The mask acts in the same cycle.
- R9: After reset, `wave_o` is 0, `sample_flag_o` is 0 and `irq_no` is 1.
- R10: In a cycle without a strobe, `wave_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Strobe at the base rate, shared by all six streams |
| cur_a_i | input | 24 | Current sample, phase A |
| cur_b_i | input | 24 | Current sample, phase B |
| cur_c_i | input | 24 | Current sample, phase C |
| vol_a_i | input | 16 | Voltage sample, phase A |
| vol_b_i | input | 16 | Voltage sample, phase B |
| vol_c_i | input | 16 | Voltage sample, phase C |
| src_sel_i | input | 3 | Source: 000 current, 001 voltage, others disable capture |
| phase_sel_i | input | 2 | Phase: 00 A, 01 B, 10 C, 11 none |
| rate_sel_i | input | 2 | Decimation exponent k, ratio 2^k |
| ready_mask_i | input | 1 | 1 lets the flag drive the interrupt |
| status_clr_i | input | 1 | Pulse that clears the flag |
| wave_o | output | 24 | Waveform register |
| sample_flag_o | output | 1 | Sample-ready flag |
| irq_no | output | 1 | Interrupt, active low |

## Verification
A strobe that is kept updates `wave_o` and `sample_flag_o` at the next rising edge, so the bench drives each strobe for one cycle starting at a falling edge and reads the outputs at the following falling edge. A mode change is applied a full cycle before its first strobe, so it reaches the restart logic with no race. `irq_no` follows the mask with no register in between, so the bench checks it a short delay after changing the mask, without waiting for a clock edge. Checks of hold and ignore behaviour read `wave_o` and the flag after the ignored strobe and before the next stimulus.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic [2:0] {
    SRC_CUR = 3'b000,
    SRC_VOL = 3'b001
  } src_e;

  typedef enum logic [1:0] {
    PH_A    = 2'b00,
    PH_B    = 2'b01,
    PH_C    = 2'b10,
    PH_NONE = 2'b11
  } phase_e;

  localparam int unsigned NUM_PH = 3;
endpackage

// File: rtl/wc_src_mux.sv
module wc_src_mux
  import wc_pkg::*;
#(
  parameter int unsigned CUR_W = 24,
  parameter int unsigned VOL_W = 16
) (
  input  logic [NUM_PH*CUR_W-1:0] cur_bus_i,
  input  logic [NUM_PH*VOL_W-1:0] vol_bus_i,
  input  logic [2:0]              src_i,
  input  logic [1:0]              phase_i,
  output logic [CUR_W-1:0]        sample_o,
  output logic                    sel_ok_o
);
  localparam int unsigned EXT_W = CUR_W - VOL_W;

  logic [CUR_W-1:0] cur_arr [NUM_PH];
  logic [CUR_W-1:0] vol_ext [NUM_PH];

  // unpack per phase, sign extend voltage
  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    logic [VOL_W-1:0] v;
    assign v          = vol_bus_i[p*VOL_W +: VOL_W];
    assign cur_arr[p] = cur_bus_i[p*CUR_W +: CUR_W];
    assign vol_ext[p] = {{EXT_W{v[VOL_W-1]}}, v};
  end

  logic             src_ok;
  logic             ph_ok;
  logic [CUR_W-1:0] cur_pick;
  logic [CUR_W-1:0] vol_pick;

  always_comb begin
    cur_pick = '0;
    vol_pick = '0;
    ph_ok    = 1'b1;
    unique case (phase_i)
      PH_A: begin cur_pick = cur_arr[0]; vol_pick = vol_ext[0]; end
      PH_B: begin cur_pick = cur_arr[1]; vol_pick = vol_ext[1]; end
      PH_C: begin cur_pick = cur_arr[2]; vol_pick = vol_ext[2]; end
      default: ph_ok = 1'b0;
    endcase
  end

  always_comb begin
    src_ok   = 1'b0;
    sample_o = cur_pick;
    case (src_i)
      SRC_CUR: begin src_ok = 1'b1; sample_o = cur_pick; end
      SRC_VOL: begin src_ok = 1'b1; sample_o = vol_pick; end
      default: src_ok = 1'b0;
    endcase
  end

  assign sel_ok_o = src_ok & ph_ok;
endmodule

// File: rtl/wc_decim.sv
module wc_decim #(
  parameter int unsigned RATE_W = 2,
  parameter int unsigned MODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              valid_i,
  input  logic              sel_ok_i,
  output logic              keep_o
);
  localparam int unsigned MAX_EXP = (1 << RATE_W) - 1;
  localparam int unsigned CNT_W   = (MAX_EXP < 1) ? 1 : MAX_EXP;

  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_eff, cnt_mask;
  logic              mode_chg;

  assign mode_chg = (mode_i != mode_q);
  assign cnt_eff  = mode_chg ? '0 : cnt_q;
  // ratio 2^k : wrap mask has k low ones
  assign cnt_mask = CNT_W'((({{CNT_W{1'b0}}, 1'b1} << rate_i) - 1'b1));

  always_comb begin
    cnt_d = cnt_eff;
    if (valid_i) cnt_d = (cnt_eff + 1'b1) & cnt_mask;
  end

  assign keep_o = valid_i & sel_ok_i & (cnt_eff == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_i;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/wc_irq_flag.sv
module wc_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic flag_o,
  output logic irq_no
);
  logic flag_q;

  // a new sample wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_no = ~(flag_q & mask_i);
endmodule

// File: rtl/wave_capture_top.sv
module wave_capture_top
  import wc_pkg::*;
#(
  parameter int unsigned CUR_W  = 24,
  parameter int unsigned VOL_W  = 16,
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [CUR_W-1:0]  cur_a_i,
  input  logic [CUR_W-1:0]  cur_b_i,
  input  logic [CUR_W-1:0]  cur_c_i,
  input  logic [VOL_W-1:0]  vol_a_i,
  input  logic [VOL_W-1:0]  vol_b_i,
  input  logic [VOL_W-1:0]  vol_c_i,
  input  logic [2:0]        src_sel_i,
  input  logic [1:0]        phase_sel_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              ready_mask_i,
  input  logic              status_clr_i,
  output logic [CUR_W-1:0]  wave_o,
  output logic              sample_flag_o,
  output logic              irq_no
);
  localparam int unsigned MODE_W = 3 + 2 + RATE_W;

  logic [NUM_PH*CUR_W-1:0] cur_bus;
  logic [NUM_PH*VOL_W-1:0] vol_bus;
  logic [CUR_W-1:0]        sample;
  logic                    sel_ok;
  logic                    keep;
  logic [CUR_W-1:0]        wave_q;

  assign cur_bus = {cur_c_i, cur_b_i, cur_a_i};
  assign vol_bus = {vol_c_i, vol_b_i, vol_a_i};

  wc_src_mux #(.CUR_W(CUR_W), .VOL_W(VOL_W)) u_mux (
    .cur_bus_i (cur_bus),
    .vol_bus_i (vol_bus),
    .src_i     (src_sel_i),
    .phase_i   (phase_sel_i),
    .sample_o  (sample),
    .sel_ok_o  (sel_ok)
  );

  wc_decim #(.RATE_W(RATE_W), .MODE_W(MODE_W)) u_decim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   ({src_sel_i, phase_sel_i, rate_sel_i}),
    .rate_i   (rate_sel_i),
    .valid_i  (smp_valid_i),
    .sel_ok_i (sel_ok),
    .keep_o   (keep)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wave_q <= '0;
    else if (keep) wave_q <= sample;
  end

  wc_irq_flag u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (keep),
    .clr_i  (status_clr_i),
    .mask_i (ready_mask_i),
    .flag_o (sample_flag_o),
    .irq_no (irq_no)
  );

  assign wave_o = wave_q;
endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
  parameter int unsigned CUR_W  = 24,
  parameter int unsigned VOL_W  = 16,
  parameter int unsigned RATE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_valid_i,
  input logic [CUR_W-1:0]  cur_a_i,
  input logic [VOL_W-1:0]  vol_a_i,
  input logic [2:0]        src_sel_i,
  input logic [1:0]        phase_sel_i,
  input logic [RATE_W-1:0] rate_sel_i,
  input logic              ready_mask_i,
  input logic              status_clr_i,
  input logic [CUR_W-1:0]  wave_o,
  input logic              sample_flag_o,
  input logic              irq_no
);
  localparam int unsigned EXT_W = CUR_W - VOL_W;

  AST_CUR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && src_sel_i == 3'b000 && phase_sel_i == 2'b00 && rate_sel_i == '0)
    |=> wave_o == $past(cur_a_i)); // R1

  AST_VOL_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && src_sel_i == 3'b001 && phase_sel_i == 2'b00 && rate_sel_i == '0)
    |=> wave_o == {{EXT_W{$past(vol_a_i[VOL_W-1])}}, $past(vol_a_i)}); // R2

  AST_NO_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_sel_i == 2'b11) |=> $stable(wave_o)); // R3

  AST_SRC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i[2:1] != 2'b00) |=> $stable(wave_o)); // R4

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && src_sel_i[2:1] == 2'b00 && phase_sel_i != 2'b11 && rate_sel_i == '0)
    |=> sample_flag_o); // R7

  AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_clr_i && !smp_valid_i) |=> !sample_flag_o); // R7

  AST_FLAG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_flag_o && !status_clr_i) |=> sample_flag_o); // R7

  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == !(sample_flag_o && ready_mask_i)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(wave_o)); // R10
endmodule

bind wave_capture_top wc_checker #(
  .CUR_W(CUR_W), .VOL_W(VOL_W), .RATE_W(RATE_W)
) u_wc_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .smp_valid_i   (smp_valid_i),
  .cur_a_i       (cur_a_i),
  .vol_a_i       (vol_a_i),
  .src_sel_i     (src_sel_i),
  .phase_sel_i   (phase_sel_i),
  .rate_sel_i    (rate_sel_i),
  .ready_mask_i  (ready_mask_i),
  .status_clr_i  (status_clr_i),
  .wave_o        (wave_o),
  .sample_flag_o (sample_flag_o),
  .irq_no        (irq_no)
);

// File: tb/tb_wave_capture_top.sv
module tb_wave_capture_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [23:0] cur_a = '0, cur_b = '0, cur_c = '0;
  logic [15:0] vol_a = '0, vol_b = '0, vol_c = '0;
  logic [2:0]  src = 3'b000;
  logic [1:0]  ph = 2'b00;
  logic [1:0]  rate = 2'b00;
  logic        mask = 1'b0;
  logic        clr = 1'b0;
  logic [23:0] wave;
  logic        flag;
  logic        irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wave_capture_top dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid),
    .cur_a_i(cur_a), .cur_b_i(cur_b), .cur_c_i(cur_c),
    .vol_a_i(vol_a), .vol_b_i(vol_b), .vol_c_i(vol_c),
    .src_sel_i(src), .phase_sel_i(ph), .rate_sel_i(rate),
    .ready_mask_i(mask), .status_clr_i(clr),
    .wave_o(wave), .sample_flag_o(flag), .irq_no(irq_n)
  );

  typedef struct packed {
    logic [2:0]  src;
    logic [1:0]  ph;
    logic [23:0] cur;
    logic [15:0] vol;
    logic [23:0] exp_w;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{3'b000, 2'b00, 24'h123456, 16'h0000, 24'h123456},
    '{3'b000, 2'b01, 24'h800001, 16'h0000, 24'h800001},
    '{3'b000, 2'b10, 24'h7FFFFF, 16'h0000, 24'h7FFFFF},
    '{3'b001, 2'b00, 24'h000000, 16'h8000, 24'hFF8000},
    '{3'b001, 2'b01, 24'h000000, 16'h7FFF, 24'h007FFF},
    '{3'b001, 2'b10, 24'h000000, 16'hFFFF, 24'hFFFFFF},
    '{3'b001, 2'b00, 24'h000000, 16'h0001, 24'h000001}
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  // decoys on the unselected channels, then the sample on the chosen one
  task automatic load(input logic [1:0] p, input logic [23:0] c, input logic [15:0] v);
    cur_a = 24'h5A5A5A; cur_b = 24'hA5A5A5; cur_c = 24'h3C3C3C;
    vol_a = 16'hA5A5;   vol_b = 16'h5A5A;   vol_c = 16'hC3C3;
    case (p)
      2'b00: begin cur_a = c; vol_a = v; end
      2'b01: begin cur_b = c; vol_b = v; end
      2'b10: begin cur_c = c; vol_c = v; end
      default: ;
    endcase
  endtask

  task automatic set_mode(input logic [2:0] s, input logic [1:0] p, input logic [1:0] r);
    @(negedge clk);
    src = s; ph = p; rate = r;
  endtask

  task automatic strobe;
    @(negedge clk); valid = 1'b1;
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic clear_flag;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] last;
    repeat (3) @(negedge clk);
    check("R9 wave", wave, 24'h0);
    check("R9 flag", {23'b0, flag}, 24'h0);
    check("R9 irq", {23'b0, irq_n}, 24'h1);
    rst_n = 1'b1;

    // R1 R2 R3: table walk
    for (int i = 0; i < 7; i++) begin
      set_mode(VEC[i].src, VEC[i].ph, 2'b00);
      load(VEC[i].ph, VEC[i].cur, VEC[i].vol);
      strobe();
      check("R1/R2/R3 table", wave, VEC[i].exp_w);
    end

    // R10: no strobe, input change ignored
    load(2'b00, 24'hABCDEF, 16'h1234);
    repeat (3) @(negedge clk);
    check("R10 hold", wave, 24'h000001);

    // R4: disabled source code
    clear_flag();
    set_mode(3'b010, 2'b00, 2'b00);
    strobe();
    check("R4 wave", wave, 24'h000001);
    check("R4 flag", {23'b0, flag}, 24'h0);
    set_mode(3'b111, 2'b01, 2'b00);
    strobe();
    check("R4 wave 111", wave, 24'h000001);

    // R3: phase 11 captures nothing
    set_mode(3'b000, 2'b11, 2'b00);
    strobe();
    check("R3 none", wave, 24'h000001);
    check("R3 none flag", {23'b0, flag}, 24'h0);

    // R5: divide by 4, with idle gaps between strobes
    set_mode(3'b000, 2'b00, 2'b10);
    last = wave;
    for (int i = 0; i < 9; i++) begin
      load(2'b00, 24'h100 + 24'(i), 16'h0);
      strobe();
      if (i % 2 == 1) @(negedge clk);
      if (i % 4 == 0) last = 24'h100 + 24'(i);
      check("R5 div4", wave, last);
    end
    // R5: divide by 8
    set_mode(3'b000, 2'b01, 2'b11);
    for (int i = 0; i < 10; i++) begin
      load(2'b01, 24'h200 + 24'(i), 16'h0);
      strobe();
      if (i % 8 == 0) last = 24'h200 + 24'(i);
      check("R5 div8", wave, last);
    end

    // R6: restart on field change mid-count
    set_mode(3'b000, 2'b00, 2'b01);
    load(2'b00, 24'h300, 16'h0); strobe();
    check("R6 first", wave, 24'h300);
    load(2'b00, 24'h301, 16'h0); strobe();
    check("R6 skipped", wave, 24'h300);
    set_mode(3'b000, 2'b10, 2'b01);
    load(2'b10, 24'h302, 16'h0); strobe();
    check("R6 restart phase", wave, 24'h302);
    load(2'b10, 24'h303, 16'h0); strobe();
    set_mode(3'b000, 2'b10, 2'b10);
    load(2'b10, 24'h304, 16'h0); strobe();
    check("R6 restart rate", wave, 24'h304);

    // R7 R8: flag and mask
    set_mode(3'b000, 2'b00, 2'b00);
    clear_flag();
    check("R7 cleared", {23'b0, flag}, 24'h0);
    mask = 1'b1; #1;
    check("R8 no flag irq high", {23'b0, irq_n}, 24'h1);
    strobe();
    repeat (3) @(negedge clk);
    check("R7 sticky", {23'b0, flag}, 24'h1);
    check("R8 irq low", {23'b0, irq_n}, 24'h0);
    mask = 1'b0; #1;
    check("R8 masked", {23'b0, irq_n}, 24'h1);
    mask = 1'b1;
    @(negedge clk); valid = 1'b1; clr = 1'b1;
    @(negedge clk); valid = 1'b0; clr = 1'b0;
    check("R7 set wins", {23'b0, flag}, 24'h1);
    clear_flag();
    check("R7 clr", {23'b0, flag}, 24'h0);
    check("R8 released", {23'b0, irq_n}, 24'h1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule